// File: doc/BRIEF.md
# Keyboard Controller Host Register and Command Engine

This block is the system-facing half of a keyboard controller whose commands are decoded in fixed logic instead of by firmware. The host uses chip select, read, write and one address line. With the address line low it reaches the data port. With the address line high it reaches the command port on writes and the status byte on reads. Every write lands in one shared input buffer, together with a flag that records which port was used. Replies to commands and bytes received from the keyboard are both returned through one output buffer.

The engine keeps a configuration byte and an 8-bit general output port, and it reads an 8-bit input port and the two keyboard line levels. The output port carries the system reset line, the A20 gate, the buffer-full interrupt, an input-buffer-empty flag and the two keyboard line drivers. It carries out the command set internally. Some commands take a second data byte. Two commands run a line test. Another group produces a timed low pulse on the low output-port bits, used for a fast processor reset. Keyboard bytes enter and leave through simple valid/ready handshakes with separate receiver and transmitter blocks.

Top module: `kbcHostPort`

## Requirements
- R1: A host write (csN and wrN low at a clock edge) loads the input buffer and sets status bit 1. The address line a2 of that write is stored as status bit 3: 1 marks a command, 0 marks data. Status bit 1 stays 1 until the engine consumes the byte.
- R2: A read with a2=1 returns the status byte. Its bits, from bit 7 down to bit 0, are parity error, receive timeout, transmit timeout, input-port bit 7 (1 = not inhibited), command/data flag, configuration bit 2 (system flag), input buffer full and output buffer full. A read with a2=0 returns the output buffer, and that read edge clears output buffer full.
- R3: outPort bit 4 is 1 exactly when output buffer full and configuration bit 0 are both 1. outPort bit 5 is the inverse of input buffer full. outPort bits 7:6 and 3:0 come from the stored output-port register.
- R4: Command 0x20 replies with the configuration byte. Command 0x60 stores the next data byte as the configuration byte, with bits 7 and 1 forced to 0. The configuration byte is 0x00 after reset.
- R5: Commands 0xAA and 0xAB run a line test. For one cycle both keyboard line outputs are driven low and the inputs are sampled; the outputs are then released and the inputs are sampled again. The reply is chosen in this priority: 0x01 if the clock reads low when released, 0x02 if the clock reads high when driven, 0x03 if the data line reads low when released, 0x04 if the data line reads high when driven, otherwise 0x00.
- R6: Keyboard bytes are accepted only when configuration bit 4 is 0 and, in addition, either input-port bit 7 is 1 or configuration bit 3 is 1. Command 0xAD sets configuration bit 4 and command 0xAE clears it.
- R7: Command 0xC0 replies with the input port. Command 0xD0 replies with outPort as it stands while the command is taken (bits 5:4 read 0 then). Command 0xE0 replies with bit 0 = keyboard clock input, bit 1 = keyboard data input, and all other bits 0.
- R8: Command 0xD1 stores the next data byte into the output-port register. Bits 5:4 of that byte have no effect on outPort.
- R9: A data byte that arrives while no command is waiting for data is offered on txValid/txData. It stays in the input buffer until txReady is seen; a transfer clears the transmit timeout flag.
- R10: A txTimeout pulse while a byte is offered drops the byte, clears input buffer full and sets status bit 5.
- R11: Command 0xFn pulses low every bit of outPort[3:0] whose bit in n is 0, and leaves the other bits unchanged. The low level starts PULSE_DLY+1 cycles after the host write edge and lasts PULSE_LEN cycles.
- R12: A keyboard byte is accepted (rxReady high) only while the output buffer is empty and no host byte is pending. It is placed in the output buffer, and its parity and timeout flags are copied to status bits 7 and 6.
- R13: A command written while the engine waits for the data byte of 0x60 or 0xD1 cancels that wait and is carried out itself.
- R14: After reset the status byte is 0x10 when input-port bit 7 is 1, and outPort is 0xEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| a2 | input | 1 | Port select: 0 data, 1 command/status |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Host read data |
| rxValid | input | 1 | Receiver has a keyboard byte |
| rxData | input | 8 | Received keyboard byte |
| rxParityErr | input | 1 | Parity error flag of the received byte |
| rxTimeout | input | 1 | Receive timeout flag of the received byte |
| rxReady | output | 1 | Engine takes the received byte |
| txValid | output | 1 | Byte offered to the transmitter |
| txData | output | 8 | Byte for the keyboard |
| txReady | input | 1 | Transmitter takes the byte |
| txTimeout | input | 1 | Transmitter gave up on the byte |
| inPort | input | 8 | General input port |
| testClkIn | input | 1 | Keyboard clock line level |
| testDataIn | input | 1 | Keyboard data line level |
| outPort | output | 8 | General output port |

## Verification
On every cycle, the embedded assertions check four things: a host write always leaves a full input buffer tagged with its address line, a data-port read empties the output buffer, the output buffer is never loaded while it is full, and keyboard handshakes are only offered when the buffers allow them. The bench scenarios are needed for the command results: reply values, configuration and output-port updates, the line-test codes under injected stuck lines, cancelling a pending data wait, and the transmit timeout. The exact position and width of the reset pulse is compared cycle by cycle against a counter-based model in the bench.

// File: rtl/kbcHostPkg.sv
package kbcHostPkg;
  typedef enum logic [2:0] {
    SEL_RX, SEL_CFG, SEL_INPORT, SEL_OUTPORT, SEL_LINES, SEL_LINECODE
  } replySel_e;

  typedef struct packed {
    logic      takeIb;
    logic      loadOut;
    replySel_e sel;
    logic      wrCfg;
    logic      setKbOff;
    logic      clrKbOff;
    logic      wrOutPort;
    logic      startPulse;
    logic      driveLow;
    logic      grabLow;
    logic      txDone;
    logic      txFail;
  } strobe_t;
endpackage

// File: rtl/kbcHostCtrl.sv
module kbcHostCtrl
  import kbcHostPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inFull,
  input  logic       cmdFlag,
  input  logic [7:0] ibData,
  input  logic       outFull,
  input  logic       kbEnabled,
  input  logic       rxValid,
  output logic       rxReady,
  output logic       txValid,
  input  logic       txReady,
  input  logic       txTimeout,
  output strobe_t    strb
);
  typedef enum logic [2:0] {S_IDLE, S_WAIT_CFG, S_WAIT_OP, S_TX, S_TLOW, S_THIGH} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    strb.sel  = SEL_RX;
    nextState = state;
    rxReady   = 1'b0;
    txValid   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (inFull && cmdFlag) begin
          if (!outFull) begin
            strb.takeIb = 1'b1;
            case (ibData)
              8'h20: begin strb.loadOut = 1'b1; strb.sel = SEL_CFG; end
              8'h60: nextState = S_WAIT_CFG;
              8'hAA, 8'hAB: nextState = S_TLOW;
              8'hAD: strb.setKbOff = 1'b1;
              8'hAE: strb.clrKbOff = 1'b1;
              8'hC0: begin strb.loadOut = 1'b1; strb.sel = SEL_INPORT; end
              8'hD0: begin strb.loadOut = 1'b1; strb.sel = SEL_OUTPORT; end
              8'hD1: nextState = S_WAIT_OP;
              8'hE0: begin strb.loadOut = 1'b1; strb.sel = SEL_LINES; end
              default: strb.startPulse = (ibData[7:4] == 4'hF);
            endcase
          end
        end else if (inFull) begin
          nextState = S_TX;
        end else begin
          rxReady = !outFull && kbEnabled;
          if (rxValid && rxReady) strb.loadOut = 1'b1;
        end
      end
      S_WAIT_CFG, S_WAIT_OP: begin
        if (inFull) begin
          if (cmdFlag) begin
            nextState = S_IDLE;  // new command cancels the wait
          end else begin
            strb.takeIb    = 1'b1;
            strb.wrCfg     = (state == S_WAIT_CFG);
            strb.wrOutPort = (state == S_WAIT_OP);
            nextState      = S_IDLE;
          end
        end
      end
      S_TX: begin
        txValid = 1'b1;
        if (txReady) begin
          strb.takeIb = 1'b1; strb.txDone = 1'b1; nextState = S_IDLE;
        end else if (txTimeout) begin
          strb.takeIb = 1'b1; strb.txFail = 1'b1; nextState = S_IDLE;
        end
      end
      S_TLOW: begin
        strb.driveLow = 1'b1;
        strb.grabLow  = 1'b1;
        nextState     = S_THIGH;
      end
      S_THIGH: begin
        strb.loadOut = 1'b1;
        strb.sel     = SEL_LINECODE;
        nextState    = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R9
  tx_has_data_chk: assert property (@(posedge clk) disable iff (!rstN) txValid |-> inFull);
  // R12
  rx_only_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN) rxReady |-> (!outFull && !inFull));
endmodule

// File: rtl/kbcHostDp.sv
module kbcHostDp
  import kbcHostPkg::*;
#(
  parameter int PULSE_DLY = 16,
  parameter int PULSE_LEN = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       a2,
  input  logic [7:0] hostDin,
  output logic [7:0] hostDout,
  input  strobe_t    strb,
  input  logic [7:0] rxData,
  input  logic       rxParityErr,
  input  logic       rxTimeout,
  input  logic [7:0] inPort,
  input  logic       testClkIn,
  input  logic       testDataIn,
  output logic [7:0] outPort,
  output logic       inFull,
  output logic       cmdFlag,
  output logic [7:0] ibData,
  output logic       outFull,
  output logic       kbEnabled
);
  localparam int MAXCNT = (PULSE_DLY > PULSE_LEN) ? PULSE_DLY : PULSE_LEN;
  localparam int CW     = $clog2(MAXCNT + 1);

  logic [7:0]    obData, cfgByte, opReg, reply, lineCode, status;
  logic          parErr, rxTo, txTo, lowClk, lowDat;
  logic          pulseDly, pulseAct;
  logic [CW-1:0] pulseCnt;
  logic [3:0]    pulseMask;

  assign kbEnabled = !cfgByte[4] && (inPort[7] || cfgByte[3]);
  assign status    = {parErr, rxTo, txTo, inPort[7], cmdFlag, cfgByte[2], inFull, outFull};
  assign hostDout  = a2 ? status : obData;

  always_comb begin
    outPort[7:6] = strb.driveLow ? 2'b00 : opReg[7:6];
    outPort[5]   = !inFull;
    outPort[4]   = outFull && cfgByte[0];
    outPort[3:0] = opReg[3:0] & ~(pulseAct ? pulseMask : 4'h0);
  end

  always_comb begin
    if (!testClkIn)      lineCode = 8'h01;
    else if (lowClk)     lineCode = 8'h02;
    else if (!testDataIn) lineCode = 8'h03;
    else if (lowDat)     lineCode = 8'h04;
    else                 lineCode = 8'h00;
  end

  always_comb begin
    unique case (strb.sel)
      SEL_RX:       reply = rxData;
      SEL_CFG:      reply = cfgByte;
      SEL_INPORT:   reply = inPort;
      SEL_OUTPORT:  reply = outPort;
      SEL_LINES:    reply = {6'b0, testDataIn, testClkIn};
      SEL_LINECODE: reply = lineCode;
      default:      reply = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFull <= 1'b0; cmdFlag <= 1'b0; ibData <= 8'h00;
      outFull <= 1'b0; obData <= 8'h00;
      cfgByte <= 8'h00; opReg <= 8'hFF;
      parErr <= 1'b0; rxTo <= 1'b0; txTo <= 1'b0;
      lowClk <= 1'b0; lowDat <= 1'b0;
    end else begin
      if (hostWr) begin
        inFull <= 1'b1; ibData <= hostDin; cmdFlag <= a2;
      end else if (strb.takeIb) begin
        inFull <= 1'b0;
      end
      if (strb.loadOut) begin
        outFull <= 1'b1; obData <= reply;
        if (strb.sel == SEL_RX) begin parErr <= rxParityErr; rxTo <= rxTimeout; end
      end else if (hostRd && !a2) begin
        outFull <= 1'b0;
      end
      if (strb.wrCfg)         cfgByte <= ibData & 8'h7D;
      else if (strb.setKbOff) cfgByte[4] <= 1'b1;
      else if (strb.clrKbOff) cfgByte[4] <= 1'b0;
      if (strb.wrOutPort) opReg <= ibData;
      if (strb.txFail)      txTo <= 1'b1;
      else if (strb.txDone) txTo <= 1'b0;
      if (strb.grabLow) begin lowClk <= testClkIn; lowDat <= testDataIn; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseDly <= 1'b0; pulseAct <= 1'b0; pulseCnt <= '0; pulseMask <= 4'h0;
    end else if (strb.startPulse) begin
      pulseDly <= 1'b1; pulseAct <= 1'b0;
      pulseCnt <= CW'(PULSE_DLY - 1); pulseMask <= ~ibData[3:0];
    end else if (pulseDly) begin
      if (pulseCnt == '0) begin
        pulseDly <= 1'b0; pulseAct <= 1'b1; pulseCnt <= CW'(PULSE_LEN - 1);
      end else pulseCnt <= pulseCnt - 1'b1;
    end else if (pulseAct) begin
      if (pulseCnt == '0) pulseAct <= 1'b0;
      else pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // R1
  write_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> (inFull && cmdFlag == $past(a2)));
  // R2
  read_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !a2 && !strb.loadOut) |=> !outFull);
  // R12
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOut |-> !outFull);
endmodule

// File: rtl/kbcHostPort.sv
module kbcHostPort
  import kbcHostPkg::*;
#(
  parameter int PULSE_DLY = 16,
  parameter int PULSE_LEN = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       a2,
  input  logic [7:0] hostDin,
  output logic [7:0] hostDout,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxParityErr,
  input  logic       rxTimeout,
  output logic       rxReady,
  output logic       txValid,
  output logic [7:0] txData,
  input  logic       txReady,
  input  logic       txTimeout,
  input  logic [7:0] inPort,
  input  logic       testClkIn,
  input  logic       testDataIn,
  output logic [7:0] outPort
);
  strobe_t    strb;
  logic       inFull, cmdFlag, outFull, kbEnabled;
  logic [7:0] ibData;
  logic       hostWr, hostRd;

  assign hostWr = !csN && !wrN;
  assign hostRd = !csN && !rdN;
  assign txData = ibData;

  kbcHostCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inFull(inFull), .cmdFlag(cmdFlag), .ibData(ibData),
    .outFull(outFull), .kbEnabled(kbEnabled), .rxValid(rxValid), .rxReady(rxReady),
    .txValid(txValid), .txReady(txReady), .txTimeout(txTimeout), .strb(strb)
  );

  kbcHostDp #(.PULSE_DLY(PULSE_DLY), .PULSE_LEN(PULSE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .a2(a2),
    .hostDin(hostDin), .hostDout(hostDout), .strb(strb), .rxData(rxData),
    .rxParityErr(rxParityErr), .rxTimeout(rxTimeout), .inPort(inPort),
    .testClkIn(testClkIn), .testDataIn(testDataIn), .outPort(outPort),
    .inFull(inFull), .cmdFlag(cmdFlag), .ibData(ibData), .outFull(outFull),
    .kbEnabled(kbEnabled)
  );
endmodule

// File: tb/test_kbcHostPort.sv
`timescale 1ns/1ps
module test_kbcHostPort;
  localparam int DLY = 16;
  localparam int LEN = 48;

  logic clk = 0, rstN = 0, csN = 1, rdN = 1, wrN = 1, a2 = 0;
  logic [7:0] hostDin = 0, hostDout, rxData = 0, txData, inPort = 8'hFF, outPort;
  logic rxValid = 0, rxParityErr = 0, rxTimeout = 0, rxReady, txValid, txReady = 0, txTimeout = 0;
  logic clkLo = 0, clkHi = 0, datLo = 0, datHi = 0;
  logic testClkIn, testDataIn;
  int compared = 0, mismatched = 0;
  bit done = 0;

  assign testClkIn  = (outPort[6] | clkHi) & ~clkLo;
  assign testDataIn = (outPort[7] | datHi) & ~datLo;

  always #2.5 clk = ~clk;

  kbcHostPort #(.PULSE_DLY(DLY), .PULSE_LEN(LEN)) i_kbcHostPort (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .a2(a2),
    .hostDin(hostDin), .hostDout(hostDout), .rxValid(rxValid), .rxData(rxData),
    .rxParityErr(rxParityErr), .rxTimeout(rxTimeout), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady), .txTimeout(txTimeout),
    .inPort(inPort), .testClkIn(testClkIn), .testDataIn(testDataIn), .outPort(outPort)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic port, input logic [7:0] d);
    @(negedge clk); csN = 0; wrN = 0; a2 = port; hostDin = d;
    @(negedge clk); csN = 1; wrN = 1;
  endtask

  task automatic hostRead(input logic port, output logic [7:0] d);
    @(negedge clk); csN = 0; rdN = 0; a2 = port; #0.5 d = hostDout;
    @(negedge clk); csN = 1; rdN = 1;
  endtask

  task automatic readReply(input string req, input logic [7:0] exp);
    logic [7:0] s, d;
    s = 0;
    for (int i = 0; i < 40 && !s[0]; i++) hostRead(1, s);
    hostRead(0, d);
    chk(req, d, exp);
  endtask

  task automatic kbSend(input logic [7:0] d, input logic p, input logic t,
                        input int maxWait, output bit took);
    @(negedge clk); rxValid = 1; rxData = d; rxParityErr = p; rxTimeout = t; took = 0;
    for (int i = 0; i < maxWait && !took; i++) begin
      if (rxReady) took = 1;
      @(negedge clk);
    end
    rxValid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] s, d;
    bit took;
    idle(3); rstN = 1; idle(1);
    // R14 reset state
    hostRead(1, s); chk("R14 status", s, 8'h10);
    chk("R14 outPort", outPort, 8'hEF);

    // R12 R2 receive and read back
    kbSend(8'h1C, 0, 0, 20, took); chk("R12 taken", {7'b0, took}, 8'h01);
    hostRead(1, s); chk("R2 status full", s, 8'h11);
    chk("R3 irq off while cfg bit0=0", {7'b0, outPort[4]}, 8'h00);
    hostRead(0, d); chk("R2 data", d, 8'h1C);
    hostRead(1, s); chk("R2 emptied", s & 8'h01, 8'h00);

    // R4 write configuration
    hostWrite(1, 8'h60); hostWrite(0, 8'h05); idle(2);
    hostRead(1, s); chk("R4 system flag", s & 8'h04, 8'h04);
    kbSend(8'hAB, 1, 1, 20, took);
    hostRead(1, s); chk("R12 flags", s, 8'hD5);
    chk("R3 irq on", {7'b0, outPort[4]}, 8'h01);
    kbSend(8'h99, 0, 0, 6, took); chk("R12 refused while full", {7'b0, took}, 8'h00);
    // R1 command held while output buffer full
    hostWrite(1, 8'hC0); idle(2);
    hostRead(1, s); chk("R1 command pending", s & 8'h0A, 8'h0A);
    chk("R3 input empty bit", {7'b0, outPort[5]}, 8'h00);
    hostRead(0, d); chk("R12 data", d, 8'hAB);
    readReply("R7 input port", 8'hFF);

    // R9 transmit
    hostWrite(0, 8'h5A); idle(2);
    hostRead(1, s); chk("R1 data pending", s & 8'h0A, 8'h02);
    chk("R9 txValid", {7'b0, txValid}, 8'h01);
    chk("R9 txData", txData, 8'h5A);
    txReady = 1; idle(1); txReady = 0; idle(1);
    hostRead(1, s); chk("R9 consumed", s & 8'h22, 8'h00);
    // R10 timeout
    hostWrite(0, 8'h33); idle(2);
    txTimeout = 1; idle(1); txTimeout = 0; idle(1);
    hostRead(1, s); chk("R10 flag set", s & 8'h22, 8'h20);
    hostWrite(0, 8'h34); idle(2);
    txReady = 1; idle(1); txReady = 0; idle(1);
    hostRead(1, s); chk("R9 timeout cleared", s & 8'h20, 8'h00);

    // R4 readback and masking
    hostWrite(1, 8'h20); readReply("R4 read cfg", 8'h05);
    hostWrite(1, 8'h60); hostWrite(0, 8'hFF);
    hostWrite(1, 8'h20); readReply("R4 masked cfg", 8'h7D);
    // R6 enable/disable
    kbSend(8'h11, 0, 0, 6, took); chk("R6 disabled by cfg", {7'b0, took}, 8'h00);
    hostWrite(1, 8'hAE); idle(2);
    kbSend(8'h12, 0, 0, 6, took); chk("R6 enabled", {7'b0, took}, 8'h01);
    hostRead(0, d);
    hostWrite(1, 8'hAD); idle(2);
    kbSend(8'h13, 0, 0, 6, took); chk("R6 disabled by AD", {7'b0, took}, 8'h00);
    hostWrite(1, 8'h60); hostWrite(0, 8'h01);
    inPort = 8'h7F; idle(1);
    kbSend(8'h14, 0, 0, 6, took); chk("R6 inhibited", {7'b0, took}, 8'h00);
    hostRead(1, s); chk("R2 inhibit bit", s & 8'h10, 8'h00);
    inPort = 8'hFF;

    // R7 replies
    hostWrite(1, 8'hD0); readReply("R7 output port", 8'hCF);
    hostWrite(1, 8'hE0); readReply("R7 lines", 8'h03);
    inPort = 8'hA5; hostWrite(1, 8'hC0); readReply("R7 input port", 8'hA5);
    inPort = 8'hFF;

    // R8 write output port
    hostWrite(1, 8'hD1); hostWrite(0, 8'h3C); idle(2);
    chk("R8 outPort", outPort, 8'h2C);
    hostWrite(1, 8'hE0); readReply("R7 lines low", 8'h00);
    hostWrite(1, 8'hAA); readReply("R5 clock held low", 8'h01);
    hostWrite(1, 8'hD1); hostWrite(0, 8'hFF); idle(2);
    chk("R8 restored", outPort, 8'hEF);

    // R5 line test
    hostWrite(1, 8'hAA); readReply("R5 clean", 8'h00);
    clkLo = 1; hostWrite(1, 8'hAB); readReply("R5 clk stuck low", 8'h01); clkLo = 0;
    clkHi = 1; hostWrite(1, 8'hAA); readReply("R5 clk stuck high", 8'h02); clkHi = 0;
    datLo = 1; hostWrite(1, 8'hAB); readReply("R5 data stuck low", 8'h03); datLo = 0;
    datHi = 1; hostWrite(1, 8'hAA); readReply("R5 data stuck high", 8'h04); datHi = 0;

    // R13 cancelled wait
    hostWrite(1, 8'h60); hostWrite(1, 8'h20); readReply("R13 cancel", 8'h01);

    // R11 pulse, compared on every clock
    hostWrite(1, 8'hFA);
    for (int j = 0; j < DLY + LEN + 20; j++) begin
      chk("R11 pulse", {4'h0, outPort[3:0]},
          (j >= DLY + 1 && j <= DLY + LEN) ? 8'h0A : 8'h0F);
      @(negedge clk);
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule